// File: doc/BRIEF.md
# IR Remote Carrier Modulator

The block drives an infrared remote-control output pin. A carrier is built from two programmable durations, a high time and a low time, both counted in system-clock cycles. The carrier is gated by a single output-data bit, so the pin shows bursts of carrier wherever that bit is 1 and stays low wherever it is 0. Software encodes the protocol by choosing envelope segment lengths and levels.

A 16-bit segment counter times each envelope segment against a 16-bit segment-length register. When the counter reaches that value, the block pulses an interrupt and restarts the count. In the same cycle it loads the next length from a double buffer and the next output level from an output buffer. Software therefore refills both buffers during a segment, and the envelope steps on with no software latency at the boundary. A mask option drops the carrier and sends the data bit out alone. Whenever the data bit rises, the carrier restarts at the start of its high phase, so the first pulse of every burst has full width.

Top module: `irm_modulator`

All registers are written through one byte-wide port. The register map is: address 0 holds the control bits (bit0 carrier enable, bit1 carrier mask, bit2 segment run); address 1 holds the high time; address 2 holds the low time; address 3 is the low byte of the length buffer; address 4 is the high byte of the length buffer; address 5 is the output buffer (bit0); address 6 writes the output-data bit directly (bit0).

## Requirements
- R1: With carrier enable 1 and mask 0, `rem_o` is the carrier ANDed with the output-data bit.
- R2: With carrier enable 1, the carrier is high for (high time + 1) cycles and then low for (low time + 1) cycles, repeating. It starts in the high phase in the first cycle after enable is set.
- R3: With carrier enable 0 and mask 0, `rem_o` is 0 whatever the output-data bit is.
- R4: With mask 1, `rem_o` equals the output-data bit, with no carrier.
- R5: With run 1, `irq_o` is a one-cycle pulse that appears (L + 1) cycles after run was set or after the previous pulse. L is the segment length in force, and L = 0 yields a pulse every cycle.
- R6: At each match, the segment-length register takes the buffer value and the output-data bit takes the output buffer, both visible in the pulse cycle. A buffer written during a segment therefore sets the length of the segment that follows the next pulse.
- R7: With run 0, the counter is held at 0, `irq_o` stays 0, and the segment-length register follows the buffer.
- R8: After reset, `rem_o` and `irq_o` are 0, and the length buffer and length register both hold 0xFFFF. Starting run without any writes therefore gives the first pulse after 65536 cycles.
- R9: When the output-data bit goes from 0 to 1, either by direct write or by an envelope load, the carrier restarts its high phase for a full (high time + 1) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| rem_o | output | 1 | Remote-out pin |
| irq_o | output | 1 | Segment match interrupt pulse |

## Verification
A register write takes effect at the clock edge that samples it, and both outputs change right after that edge. The carrier pattern therefore begins on the first sampling point after the enabling write, and a restart takes effect in the first sample after the rising write. The interrupt and the new output level appear together exactly L + 1 cycles after the run write or after the previous pulse. The bench samples on falling edges and counts those edges from the edge at which each write task returns. Each write contributes two edges to that count, so the expected intervals in the envelope test include the writes made between pulses.

// File: rtl/irm_pkg.sv
package irm_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_HIGH   = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOW    = 3'd2;
  localparam logic [ADDR_W-1:0] A_BUF_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_BUF_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_OBUF   = 3'd5;
  localparam logic [ADDR_W-1:0] A_OUT    = 3'd6;

  typedef struct packed {
    logic run;
    logic mask;
    logic cen;
  } ctrl_t;
endpackage

// File: rtl/irm_regs.sv
module irm_regs
  import irm_pkg::*;
#(
  parameter int CAR_W = 8,
  parameter int SEG_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic [CAR_W-1:0]  high_o,
  output logic [CAR_W-1:0]  low_o,
  output logic [SEG_W-1:0]  buf_o,
  output logic              obuf_o,
  output logic              dir_we_o,
  output logic              dir_val_o
);
  localparam int HI_W = SEG_W - BYTE_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      high_o <= '0;
      low_o  <= '0;
      buf_o  <= '1;
      obuf_o <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL:   ctrl_o <= ctrl_t'(wr_data_i[2:0]);
        A_HIGH:   high_o <= wr_data_i[CAR_W-1:0];
        A_LOW:    low_o  <= wr_data_i[CAR_W-1:0];
        A_BUF_LO: buf_o[BYTE_W-1:0] <= wr_data_i;
        A_BUF_HI: buf_o[SEG_W-1:BYTE_W] <= wr_data_i[HI_W-1:0];
        A_OBUF:   obuf_o <= wr_data_i[0];
        default:  ;
      endcase
    end
  end

  assign dir_we_o  = wr_en_i && (wr_addr_i == A_OUT);
  assign dir_val_o = wr_data_i[0];
endmodule

// File: rtl/irm_carrier.sv
module irm_carrier #(
  parameter int CAR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cen_i,
  input  logic             restart_i,
  input  logic [CAR_W-1:0] high_i,
  input  logic [CAR_W-1:0] low_i,
  output logic             carrier_o
);
  logic             phase_q;
  logic [CAR_W-1:0] cnt_q;
  logic [CAR_W-1:0] lim;

  assign lim = phase_q ? high_i : low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b1;
      cnt_q   <= '0;
    end else if (!cen_i || restart_i) begin
      phase_q <= 1'b1;
      cnt_q   <= '0;
    end else if (cnt_q == lim) begin
      phase_q <= ~phase_q;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign carrier_o = phase_q;

  p_hold_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_i && !restart_i && cnt_q != lim) |=> (phase_q == $past(phase_q)));
  p_flip_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_i && !restart_i && cnt_q == lim) |=> (phase_q != $past(phase_q)));
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (phase_q && cnt_q == '0));
endmodule

// File: rtl/irm_envelope.sv
module irm_envelope #(
  parameter int SEG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEG_W-1:0] buf_i,
  input  logic             obuf_i,
  input  logic             dir_we_i,
  input  logic             dir_val_i,
  output logic             out_o,
  output logic             restart_o,
  output logic             irq_o
);
  logic [SEG_W-1:0] cnt_q;
  logic [SEG_W-1:0] len_q;
  logic             out_q;
  logic             match;
  logic             load;
  logic             out_d;

  assign match = (cnt_q == len_q);
  assign load  = run_i && match;

  always_comb begin
    out_d = out_q;
    if (load)          out_d = obuf_i;
    else if (dir_we_i) out_d = dir_val_i;
  end

  assign restart_o = out_d && !out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= '1;
      irq_o <= 1'b0;
      out_q <= 1'b0;
    end else begin
      out_q <= out_d;
      if (!run_i) begin
        cnt_q <= '0;
        len_q <= buf_i;
        irq_o <= 1'b0;
      end else if (match) begin
        cnt_q <= '0;
        len_q <= buf_i;
        irq_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        irq_o <= 1'b0;
      end
    end
  end

  assign out_o = out_q;

  p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && len_q != '0) |=> !irq_o);
  p_len_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (len_q == $past(buf_i) && out_q == $past(obuf_i)));
  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!irq_o && cnt_q == '0));
endmodule

// File: rtl/irm_modulator.sv
module irm_modulator
  import irm_pkg::*;
#(
  parameter int CAR_W = 8,
  parameter int SEG_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              rem_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [CAR_W-1:0] high;
  logic [CAR_W-1:0] low;
  logic [SEG_W-1:0] seg_buf;
  logic             obuf;
  logic             dir_we;
  logic             dir_val;
  logic             out_bit;
  logic             restart;
  logic             carrier;

  irm_regs #(.CAR_W(CAR_W), .SEG_W(SEG_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .high_o(high), .low_o(low), .buf_o(seg_buf),
    .obuf_o(obuf), .dir_we_o(dir_we), .dir_val_o(dir_val)
  );

  irm_envelope #(.SEG_W(SEG_W)) u_env (
    .clk_i, .rst_ni, .run_i(ctrl.run), .buf_i(seg_buf), .obuf_i(obuf),
    .dir_we_i(dir_we), .dir_val_i(dir_val), .out_o(out_bit),
    .restart_o(restart), .irq_o
  );

  irm_carrier #(.CAR_W(CAR_W)) u_car (
    .clk_i, .rst_ni, .cen_i(ctrl.cen), .restart_i(restart),
    .high_i(high), .low_i(low), .carrier_o(carrier)
  );

  // mask passes the data bit alone; otherwise the enabled carrier gates it
  assign rem_o = out_bit && (ctrl.mask || (ctrl.cen && carrier));

  p_low_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_bit |-> !rem_o);
endmodule

// File: tb/irm_modulator_test.sv
module irm_modulator_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       rem_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irm_modulator uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!irq_o && n < 70000);
  endtask

  task automatic t_reset;
    chk("R8 rem after reset", rem_o, 0);
    chk("R8 irq after reset", irq_o, 0);
  endtask

  task automatic t_carrier;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'd2);
    wr(3'd2, 8'd4);
    wr(3'd6, 8'h01);
    wr(3'd0, 8'h01);
    for (int p = 0; p < 16; p++) begin
      chk($sformatf("R1 R2 carrier p=%0d", p), rem_o, ((p % 8) < 3) ? 1 : 0);
      @(negedge clk_i);
    end
  endtask

  task automatic t_gate_mask;
    int hits;
    wr(3'd0, 8'h00);
    hits = 0;
    for (int p = 0; p < 10; p++) begin
      hits += rem_o;
      @(negedge clk_i);
    end
    chk("R3 carrier off gives low", hits, 0);
    wr(3'd0, 8'h02);
    chk("R4 mask shows data 1", rem_o, 1);
    wr(3'd6, 8'h00);
    chk("R4 mask shows data 0", rem_o, 0);
    wr(3'd0, 8'h03);
    wr(3'd6, 8'h01);
    hits = 0;
    for (int p = 0; p < 12; p++) begin
      hits += rem_o;
      @(negedge clk_i);
    end
    chk("R4 mask removes carrier", hits, 12);
  endtask

  task automatic t_restart;
    wr(3'd0, 8'h00);
    wr(3'd6, 8'h00);
    wr(3'd1, 8'd3);
    wr(3'd2, 8'd3);
    wr(3'd0, 8'h01);
    wr(3'd6, 8'h01);
    for (int p = 0; p < 8; p++) begin
      chk($sformatf("R9 restart p=%0d", p), rem_o, (p < 4) ? 1 : 0);
      @(negedge clk_i);
    end
  endtask

  task automatic t_idle;
    int hits;
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h00);
    hits = 0;
    for (int p = 0; p < 20; p++) begin
      hits += irq_o;
      @(negedge clk_i);
    end
    chk("R7 no irq while stopped", hits, 0);
  endtask

  task automatic t_envelope;
    int n;
    wr(3'd0, 8'h00);
    wr(3'd3, 8'd9);
    wr(3'd4, 8'd0);
    wr(3'd5, 8'h01);
    wr(3'd6, 8'h00);
    wr(3'd0, 8'h02);
    chk("R4 envelope low before run", rem_o, 0);
    wr(3'd0, 8'h06);
    wait_irq(n);
    chk("R5 first segment length", n, 10);
    chk("R6 output loaded at first match", rem_o, 1);
    wr(3'd3, 8'd4);
    wr(3'd5, 8'h00);
    wait_irq(n);
    chk("R6 second segment keeps old length", n + 4, 10);
    chk("R6 output loaded at second match", rem_o, 0);
    @(negedge clk_i);
    chk("R5 irq is one cycle", irq_o, 0);
    wait_irq(n);
    chk("R6 third segment uses new length", n + 1, 5);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_reset_len;
    int n;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    wr(3'd0, 8'h04);
    wait_irq(n);
    chk("R8 default length 0xFFFF", n, 65536);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_carrier();
    t_gate_mask();
    t_restart();
    t_idle();
    t_envelope();
    t_reset_len();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule